// File: doc/BRIEF.md
# Ping-pong clock source selector

This block holds the control state for a processor clock source. Two 8-bit configuration banks each carry a source index and a divide value. A single select bit decides which bank drives the clock. Software reconfigures the clock without touching the running setting. It first writes the bank that is not in use, then inverts the select bit. The freshly written bank becomes live, and the old one becomes the next spare.

A separate two-bit field chooses the core clock path. The options are the divided source, a dedicated PLL, the bus clock, or a low-jitter PLL that passes through the divider. Only the divided source and the low-jitter PLL use the banked divider setting. All state is reached through a small synchronous register port with byte strobes on the bank register. The outputs are the live source index, the live divide value, the core path, a flag that says whether the divider is in the path, and a one-cycle switch-done pulse.

Top module: `clksrc_pingpong`

## Requirements
- R1: A synchronous reset sets the select bit to 1, clears both banks, sets the core path to 0, drives the live source and divide to 0 and holds switch_done low.
- R2: A write to address 0 updates bank 0 (data bits 7:0) when wstrb[0] is set, and bank 1 (bits 15:8) when wstrb[1] is set. Reading address 0 returns both banks.
- R3: Address 1 holds the select register: bit 0 is the select bit and bits 2:1 are the core path. A write to it loads both fields, and a read returns them with zeros above.
- R4: The live configuration is decoded from a fixed bit layout. When the select bit is 1 it comes from bank 0, with the source in bits 6:4 and the divide in 3:0. When the select bit is 0 it comes from bank 1, with the source in bits 14:12 and the divide in 11:8.
- R5: After a write that inverts the select bit, the live source and divide change one cycle after the select bit changes. switch_done is high for exactly the single cycle after that.
- R6: Writes to the bank that is currently live are stored but leave the live source and divide unchanged until the next inversion of the select bit.
- R7: A write to address 2 loads wdata[1:0] into the core path only. The select bit and both banks keep their values, and core_path shows the new value in the cycle after the write.
- R8: A write to address 1 that keeps the select bit at its current value updates the core path but does not reload the live configuration and raises no switch_done.
- R9: div_path_en is 1 when the core path is 0 (divided source) or 3 (low-jitter PLL), and 0 when it is 1 (dedicated PLL) or 2 (bus clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address: 0 banks, 1 select, 2 path only, 3 unused |
| wstrb | input | 2 | Byte strobes for bank writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| act_src | output | 3 | Live source index |
| act_div | output | 4 | Live divide value |
| core_path | output | 2 | Selected core clock path |
| div_path_en | output | 1 | Divider is part of the selected path |
| switch_done | output | 1 | One-cycle pulse after a bank switch completes |

## Verification
The select bit and the core path change at the clock edge that takes the write. The live source and divide follow one edge later, and switch_done rises one edge after that and lasts one cycle. The bench drives on the falling edge and samples on the next falling edge. After each switching write it reads the outputs at four consecutive falling edges, so it sees the old value, the new value, the pulse and the end of the pulse, each in the cycle it is due. Readback through rdata is sampled shortly after the address is set, because that path has no register.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int SRC_W     = 3;
    localparam int DIV_W     = 4;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int DATA_W    = NUM_BANKS * BANK_W;
    localparam int ADDR_W    = 2;
    localparam int PATH_W    = 2;

    typedef enum logic [PATH_W-1:0] {
        PATH_DIVIDED   = 2'd0,
        PATH_DEDICATED = 2'd1,
        PATH_BUS       = 2'd2,
        PATH_LOWJIT    = 2'd3
    } core_path_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_BANKS  = 2'd0,
        REG_SELECT = 2'd1,
        REG_PATH   = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             spare;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } bank_t;

    // The select bit set to 1 makes bank 0 live; 0 makes bank 1 live.
    function automatic bank_t live_bank(input logic [DATA_W-1:0] banks,
                                        input logic sel);
        return sel ? bank_t'(banks[0 +: BANK_W])
                   : bank_t'(banks[BANK_W +: BANK_W]);
    endfunction

    function automatic logic path_uses_divider(input core_path_e p);
        return (p == PATH_DIVIDED) || (p == PATH_LOWJIT);
    endfunction

endpackage

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BW = BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW/BW-1:0]   wstrb,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [DW-1:0]      banks_q,
    output logic               sel_q,
    output core_path_e         path_q,
    output logic               toggle_q
);

    localparam int NB = DW / BW;

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(addr);

    logic wr_banks, wr_select, wr_path;
    assign wr_banks  = wr_en && (addr_e == REG_BANKS);
    assign wr_select = wr_en && (addr_e == REG_SELECT);
    assign wr_path   = wr_en && (addr_e == REG_PATH);

    // Bank storage, one byte lane per bank.
    always_ff @(posedge clk) begin
        if (rst) begin
            banks_q <= '0;
        end else if (wr_banks) begin
            for (int b = 0; b < NB; b++) begin
                if (wstrb[b]) begin
                    banks_q[b*BW +: BW] <= wdata[b*BW +: BW];
                end
            end
        end
    end

    // Select bit and core path; toggle_q flags a change of the select bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b1;
            path_q   <= PATH_DIVIDED;
            toggle_q <= 1'b0;
        end else begin
            toggle_q <= 1'b0;
            if (wr_select) begin
                sel_q    <= wdata[0];
                path_q   <= core_path_e'(wdata[PATH_W:1]);
                toggle_q <= (wdata[0] != sel_q);
            end else if (wr_path) begin
                path_q <= core_path_e'(wdata[PATH_W-1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr_e)
            REG_BANKS:  rdata = banks_q;
            REG_SELECT,
            REG_PATH:   rdata[PATH_W:0] = {path_q, sel_q};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch
    import clksrc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              toggle,
    input  logic              sel,
    input  logic [DW-1:0]     banks,
    output logic [SRC_W-1:0]  act_src,
    output logic [DIV_W-1:0]  act_div,
    output logic              done
);

    bank_t next_cfg;
    logic  armed;

    assign next_cfg = live_bank(banks, sel);

    // Snapshot is reloaded only on a registered select-bit change.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_src <= '0;
            act_div <= '0;
            armed   <= 1'b0;
            done    <= 1'b0;
        end else begin
            armed <= toggle;
            done  <= armed;
            if (toggle) begin
                act_src <= next_cfg.src;
                act_div <= next_cfg.div;
            end
        end
    end

endmodule

// File: rtl/clksrc_pingpong.sv
module clksrc_pingpong
    import clksrc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_BANKS-1:0] wstrb,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [SRC_W-1:0]   act_src,
    output logic [DIV_W-1:0]   act_div,
    output logic [PATH_W-1:0]  core_path,
    output logic               div_path_en,
    output logic               switch_done
);

    logic [DATA_W-1:0] banks;
    logic              sel_bit;
    core_path_e        path;
    logic              toggle;

    clksrc_regs #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .BW (BANK_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wstrb    (wstrb),
        .wdata    (wdata),
        .rdata    (rdata),
        .banks_q  (banks),
        .sel_q    (sel_bit),
        .path_q   (path),
        .toggle_q (toggle)
    );

    clksrc_switch #(
        .DW (DATA_W)
    ) u_switch (
        .clk     (clk),
        .rst     (rst),
        .toggle  (toggle),
        .sel     (sel_bit),
        .banks   (banks),
        .act_src (act_src),
        .act_div (act_div),
        .done    (switch_done)
    );

    assign core_path   = path;
    assign div_path_en = path_uses_divider(path);

endmodule

// File: rtl/clksrc_pingpong_chk.sv
module clksrc_pingpong_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic        sel_bit,
    input logic [15:0] banks,
    input logic [2:0]  act_src,
    input logic [3:0]  act_div,
    input logic [1:0]  core_path,
    input logic        switch_done
);

    logic sel_d;
    logic flipped;
    logic [2:0] want_src;
    logic [3:0] want_div;

    always_ff @(posedge clk) begin
        if (rst) sel_d <= 1'b1;
        else     sel_d <= sel_bit;
    end

    assign flipped  = (sel_bit != sel_d);
    assign want_src = sel_bit ? banks[6:4] : banks[14:12];
    assign want_div = sel_bit ? banks[3:0] : banks[11:8];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sel_bit && core_path == 2'd0 && banks == 16'h0 && !switch_done));

    // R4
    live_decode_chk: assert property (@(posedge clk) disable iff (rst)
        flipped |=> (act_src == $past(want_src) && act_div == $past(want_div)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flipped |-> ##2 switch_done);

    // R6
    hold_live_chk: assert property (@(posedge clk) disable iff (rst)
        !flipped |=> ($stable(act_src) && $stable(act_div)));

    // R7
    path_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2) |=> ($stable(sel_bit) && $stable(banks)));

endmodule

bind clksrc_pingpong clksrc_pingpong_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .sel_bit     (sel_bit),
    .banks       (banks),
    .act_src     (act_src),
    .act_div     (act_div),
    .core_path   (core_path),
    .switch_done (switch_done)
);

// File: tb/test_clksrc_pingpong.sv
module test_clksrc_pingpong;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [1:0]  wstrb = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [2:0]  act_src;
    logic [3:0]  act_div;
    logic [1:0]  core_path;
    logic        div_path_en;
    logic        switch_done;

    int checks = 0;
    int fails  = 0;
    logic sel_m = 1'b1;

    always #4 clk = ~clk;

    clksrc_pingpong i_clksrc_pingpong (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wstrb(wstrb),
        .wdata(wdata), .rdata(rdata), .act_src(act_src), .act_div(act_div),
        .core_path(core_path), .div_path_en(div_path_en),
        .switch_done(switch_done)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive on a falling edge; returns on the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wstrb = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wstrb = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic exp_div_path(input logic [1:0] p);
        return (p == 2'd0) || (p == 2'd3);
    endfunction

    task automatic do_switch(input int s, input int d, input logic [1:0] p);
        logic [7:0] cfg;
        int old_s, old_d;
        cfg = {1'b0, s[2:0], d[3:0]};
        old_s = act_src; old_d = act_div;
        // Idle bank is bank 1 when the select bit is 1.
        wr(2'd0, sel_m ? 2'b10 : 2'b01, {cfg, cfg});
        wr(2'd1, 2'b00, {13'h0, p, ~sel_m});
        sel_m = ~sel_m;
        chk("R5 old value held", {act_src, act_div}, {old_s[2:0], old_d[3:0]});
        chk("R5 no early done", switch_done, 0);
        chk("R3 core path", core_path, p);
        chk("R9 divider flag", div_path_en, exp_div_path(p));
        @(negedge clk);
        chk("R4 live source", act_src, s);
        chk("R4 live divide", act_div, d);
        chk("R5 done not yet", switch_done, 0);
        @(negedge clk);
        chk("R5 done pulse", switch_done, 1);
        @(negedge clk);
        chk("R5 done single cycle", switch_done, 0);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 banks", v, 16'h0000);
        rd(2'd1, v); chk("R1 select", v, 16'h0001);
        chk("R1 source", act_src, 0);
        chk("R1 divide", act_div, 0);
        chk("R1 path", core_path, 0);
        chk("R1 done", switch_done, 0);

        // R2 and R6: write live bank 0 only
        wr(2'd0, 2'b01, 16'hA53C);
        rd(2'd0, v); chk("R2 lane 0 only", v, 16'h003C);
        repeat (3) @(negedge clk);
        chk("R6 live bank write held", {act_src, act_div}, 7'h00);
        chk("R6 no done", switch_done, 0);
        wr(2'd0, 2'b10, 16'hA5FF);
        rd(2'd0, v); chk("R2 lane 1 only", v, 16'hA53C);

        // Switch to bank 1: source 2, divide 5
        wr(2'd1, 2'b00, 16'h0000);
        sel_m = 1'b0;
        @(negedge clk);
        chk("R4 bank1 source", act_src, 2);
        chk("R4 bank1 divide", act_div, 5);

        // R7: path-only write
        repeat (3) @(negedge clk);
        wr(2'd2, 2'b11, 16'hFFFF);
        chk("R7 path", core_path, 3);
        rd(2'd1, v); chk("R7 select bit kept", v, 16'h0006);
        rd(2'd0, v); chk("R7 banks kept", v, 16'hA53C);
        chk("R9 low-jitter uses divider", div_path_en, 1);

        // R8: select write keeping bit 0
        wr(2'd0, 2'b11, 16'h7777);
        wr(2'd1, 2'b00, 16'h0002);
        chk("R8 path updated", core_path, 1);
        chk("R9 dedicated PLL no divider", div_path_en, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R8 no done", switch_done, 0);
            chk("R8 live unchanged", {act_src, act_div}, {3'd2, 4'd5});
            @(negedge clk);
        end

        // Sweep every source and divide value through alternating banks.
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 16; d++) begin
                do_switch(s, d, 2'((s + d) % 4));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule